// File: doc/BRIEF.md
# Data-Strobe Serial Link Bit Decoder

This block is the receive front end of a point-to-point, full-duplex data-strobe serial link. Only the receive direction is handled here. The link carries two lines, data and strobe, and exactly one of them toggles per bit. The exclusive-OR of the two lines therefore changes level once per bit and serves as the recovered bit clock. The block oversamples both lines with the system clock through a synchronizer. It treats every change of that exclusive-OR as one bit period. The data value is captured into one of two capture registers: one takes bits on a rising recovered-clock transition and the other on a falling one, so consecutive bits land alternately in each register. Received bits leave in arrival order on a valid/ready stream.

The system clock must run at more than twice the fastest bit rate. Line rates from 2 to 125 Mbps are the intended range. Three status pins are provided. One reports a sample in which both lines toggled together. One reports a bit lost to back-pressure. The third reports a line that has been quiet for longer than a programmable number of cycles. When decoding is switched off, the two synchronized pins remain visible as plain general-purpose inputs.

The stream follows these back-pressure rules. A presented bit stays on `bit_data` with `bit_valid` high until a cycle in which `bit_ready` is high. With `bit_ready` held high, every bit appears as a one-cycle valid pulse. The line itself cannot be stalled. If a new bit arrives while a presented bit is still unaccepted, the new bit is discarded and `overrun` pulses.

Top module: `ds_rx_decoder`

## Requirements
- R1: After reset, `bit_valid`, `line_err`, `overrun` and `disconnect` are all 0.
- R2: While `dec_en` is 1, each change of the level of `din` XOR `sin` produces exactly one bit, whose value is the new level of `din`. For a pin change set up before clock edge k, `bit_valid` is 0 after edge k+2 and 1 after edge k+3.
- R3: A change of the XOR to 1 stores the bit in the rising-transition capture register, and a change to 0 stores it in the falling-transition register. The stream delivers the bits in the order they arrived on the line.
- R4: When both `din` and `sin` change in the same sample, `line_err` is 1 for exactly one cycle (after edge k+2), and no bit is produced.
- R5: While `bit_valid` is 1 and `bit_ready` is 0, `bit_valid` stays 1 and `bit_data` stays unchanged.
- R6: A bit that arrives while a presented bit is unaccepted is discarded. `overrun` pulses for one cycle, and the presented bit is kept.
- R7: A bit that arrives in the same cycle as the presented bit is accepted replaces it, with no overrun.
- R8: While `dec_en` is 0, no bit, `line_err` or `disconnect` is produced. `gp_data` and `gp_strobe` always show the synchronized `din` and `sin`. Enabling the decoder after the lines have moved produces no spurious bit.
- R9: With `tmo_limit` nonzero, `disconnect` rises after about `tmo_limit` cycles without a recovered-clock change and clears at the next change. A `tmo_limit` of 0 disables the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than twice the bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| din | input | 1 | Data line from the link |
| sin | input | 1 | Strobe line from the link |
| dec_en | input | 1 | 1 enables decoding, 0 leaves the pins as plain inputs |
| tmo_limit | input | 16 | Quiet-line limit in cycles, 0 disables the timeout |
| bit_data | output | 1 | Received bit |
| bit_valid | output | 1 | Received bit is presented |
| bit_ready | input | 1 | Consumer accepts the presented bit |
| line_err | output | 1 | One-cycle pulse: both lines toggled in one sample |
| overrun | output | 1 | One-cycle pulse: a bit was dropped under back-pressure |
| disconnect | output | 1 | Line quiet for longer than the limit |
| gp_data | output | 1 | Synchronized data pin |
| gp_strobe | output | 1 | Synchronized strobe pin |

## Verification
Two functions can fall in the same cycle: a new bit reaching the output stage, and the consumer accepting the bit already presented. The bench holds `bit_ready` low until a first bit is presented. It then changes the line and raises `bit_ready` in exactly the cycle in which the second bit reaches the output register. The outcome passes if the second bit is presented with no `overrun` pulse. A separate case, with `bit_ready` kept low, shows that the same arrival then drops the new bit and pulses `overrun`.

// File: rtl/ds_rx_pkg.sv
package ds_rx_pkg;
  localparam int unsigned SYNC_DEPTH = 2;
  localparam int unsigned TMO_BITS   = 16;

  // lane indices inside the synchronized pin vector
  localparam int unsigned LANE_D = 0;
  localparam int unsigned LANE_S = 1;
  localparam int unsigned LANES  = 2;
endpackage

// File: rtl/ds_pin_sync.sv
module ds_pin_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_o
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], pin_i[g]};
    end
    assign pin_o[g] = chain[LAST];
  end
endmodule

// File: rtl/ds_edge_decode.sv
module ds_edge_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic d_s,
  input  logic s_s,
  output logic chg_o,
  output logic ev_valid,
  output logic ev_bit,
  output logic err_o
);
  logic d_p, s_p;
  logic cap_rise, cap_fall, ev_sel;
  logic xor_now, xor_old, chg, dbl;

  assign xor_now = d_s ^ s_s;
  assign xor_old = d_p ^ s_p;
  assign chg     = xor_now ^ xor_old;
  assign dbl     = (d_s ^ d_p) & (s_s ^ s_p);
  assign chg_o   = en & chg;

  // previous sample is tracked even while disabled, so enabling makes no false edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_p <= 1'b0;
      s_p <= 1'b0;
    end else begin
      d_p <= d_s;
      s_p <= s_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_rise <= 1'b0;
      cap_fall <= 1'b0;
      ev_sel   <= 1'b0;
      ev_valid <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      ev_valid <= en & chg;
      err_o    <= en & dbl;
      if (en && chg) begin
        ev_sel <= xor_now;
        if (xor_now) cap_rise <= d_s;
        else         cap_fall <= d_s;
      end
    end
  end

  assign ev_bit = ev_sel ? cap_rise : cap_fall;

  // R4
  no_bit_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !ev_valid);

  // R8
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!ev_valid && !err_o));
endmodule

// File: rtl/ds_link_timer.sv
module ds_link_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         chg,
  input  logic [W-1:0] limit,
  output logic         disc
);
  localparam logic [W-1:0] CNT_MAX = '1;
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      disc <= 1'b0;
    end else if (!en || chg) begin
      cnt  <= '0;
      disc <= 1'b0;
    end else begin
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      if (limit != '0 && cnt >= limit) disc <= 1'b1;
    end
  end

  // R9
  disc_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> !disc);
endmodule

// File: rtl/ds_bit_stream.sv
module ds_bit_stream (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_valid,
  input  logic ev_bit,
  input  logic ready,
  output logic valid,
  output logic data,
  output logic ovr
);
  logic busy;
  assign busy = valid & ~ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= 1'b0;
      ovr   <= 1'b0;
    end else begin
      ovr <= ev_valid & busy;
      if (!busy) begin
        valid <= ev_valid;
        if (ev_valid) data <= ev_bit;
      end
    end
  end

  // R5
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(data)));

  // R6
  ovr_keeps_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> valid);
endmodule

// File: rtl/ds_rx_decoder.sv
module ds_rx_decoder
  import ds_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                din,
  input  logic                sin,
  input  logic                dec_en,
  input  logic [TMO_BITS-1:0] tmo_limit,
  output logic                bit_data,
  output logic                bit_valid,
  input  logic                bit_ready,
  output logic                line_err,
  output logic                overrun,
  output logic                disconnect,
  output logic                gp_data,
  output logic                gp_strobe
);
  logic [LANES-1:0] pins_raw, pins_syn;
  logic chg, ev_valid, ev_bit;

  assign pins_raw[LANE_D] = din;
  assign pins_raw[LANE_S] = sin;

  ds_pin_sync #(.WIDTH(LANES), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pins_raw), .pin_o(pins_syn)
  );

  assign gp_data   = pins_syn[LANE_D];
  assign gp_strobe = pins_syn[LANE_S];

  ds_edge_decode u_dec (
    .clk(clk), .rst_n(rst_n), .en(dec_en),
    .d_s(pins_syn[LANE_D]), .s_s(pins_syn[LANE_S]),
    .chg_o(chg), .ev_valid(ev_valid), .ev_bit(ev_bit), .err_o(line_err)
  );

  ds_link_timer #(.W(TMO_BITS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .en(dec_en), .chg(chg),
    .limit(tmo_limit), .disc(disconnect)
  );

  ds_bit_stream u_out (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_bit(ev_bit),
    .ready(bit_ready), .valid(bit_valid), .data(bit_data), .ovr(overrun)
  );

  // R8
  no_disc_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_en |=> !disconnect);
endmodule

// File: tb/ds_rx_decoder_test.sv
module ds_rx_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0, sin = 1'b0, dec_en = 1'b0, bit_ready = 1'b1;
  logic [15:0] tmo_limit = '0;
  logic bit_data, bit_valid, line_err, overrun, disconnect, gp_data, gp_strobe;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  ds_rx_decoder uut (
    .clk(clk), .rst_n(rst_n), .din(din), .sin(sin), .dec_en(dec_en),
    .tmo_limit(tmo_limit), .bit_data(bit_data), .bit_valid(bit_valid),
    .bit_ready(bit_ready), .line_err(line_err), .overrun(overrun),
    .disconnect(disconnect), .gp_data(gp_data), .gp_strobe(gp_strobe)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  // change one line at a negedge so that din after the change equals b
  task automatic drive_bit(input logic b);
    @(negedge clk);
    if (b == din) sin = ~sin;
    else          din = b;
  endtask

  task automatic t_reset;
    edges(2);
    check("R1 valid", bit_valid, 1'b0);
    check("R1 line_err", line_err, 1'b0);
    check("R1 overrun", overrun, 1'b0);
    check("R1 disconnect", disconnect, 1'b0);
  endtask

  task automatic t_stream;
    logic [6:0] pat = 7'b1001110;
    bit_ready = 1'b1;
    for (int i = 0; i < 7; i++) begin
      drive_bit(pat[i]);
      edges(3);
      check("R2 not yet", bit_valid, 1'b0);
      edges(1);
      check("R2 valid", bit_valid, 1'b1);
      check("R3 order", bit_data, pat[i]);
      edges(1);
      check("R2 single pulse", bit_valid, 1'b0);
      edges(2);
    end
  endtask

  task automatic t_double;
    @(negedge clk);
    din = ~din; sin = ~sin;
    edges(3);
    check("R4 err", line_err, 1'b1);
    check("R4 no bit", bit_valid, 1'b0);
    edges(1);
    check("R4 err pulse", line_err, 1'b0);
    check("R4 no bit", bit_valid, 1'b0);
    edges(3);
  endtask

  task automatic t_overrun;
    logic a;
    a = ~din;
    bit_ready = 1'b0;
    drive_bit(a);
    edges(4);
    check("R5 valid", bit_valid, 1'b1);
    drive_bit(~a);
    edges(4);
    check("R6 overrun", overrun, 1'b1);
    check("R5 held", bit_valid, 1'b1);
    check("R6 kept bit", bit_data, a);
    edges(1);
    check("R6 pulse", overrun, 1'b0);
    @(negedge clk); bit_ready = 1'b1;
    edges(1);
    check("R6 drained", bit_valid, 1'b0);
    edges(3);
  endtask

  task automatic t_same_cycle;
    logic a, b;
    a = din; b = ~din;
    bit_ready = 1'b0;
    drive_bit(a);
    edges(4);
    check("R7 first", bit_data, a);
    drive_bit(b);
    edges(3);
    @(negedge clk); bit_ready = 1'b1;
    edges(1);
    check("R7 valid", bit_valid, 1'b1);
    check("R7 second", bit_data, b);
    check("R7 no overrun", overrun, 1'b0);
    edges(1);
    check("R7 done", bit_valid, 1'b0);
    edges(3);
  endtask

  task automatic t_disabled;
    @(negedge clk); dec_en = 1'b0;
    drive_bit(~din);
    edges(6);
    check("R8 no bit", bit_valid, 1'b0);
    check("R8 gp data", gp_data, din);
    check("R8 gp strobe", gp_strobe, sin);
    @(negedge clk); din = ~din; sin = ~sin;
    edges(5);
    check("R8 no err", line_err, 1'b0);
    @(negedge clk); dec_en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      edges(1);
      check("R8 no spurious", bit_valid, 1'b0);
    end
  endtask

  task automatic t_timeout;
    @(negedge clk); tmo_limit = 16'd20;
    drive_bit(~din);
    edges(10);
    check("R9 early", disconnect, 1'b0);
    edges(15);
    check("R9 set", disconnect, 1'b1);
    drive_bit(~din);
    edges(4);
    check("R9 cleared", disconnect, 1'b0);
    @(negedge clk); tmo_limit = 16'd0;
    edges(60);
    check("R9 zero limit", disconnect, 1'b0);
  endtask

  initial begin
    edges(3);
    rst_n = 1'b1;
    t_reset;
    @(negedge clk); dec_en = 1'b1;
    edges(3);
    t_stream;
    t_double;
    t_overrun;
    t_same_cycle;
    t_disabled;
    t_timeout;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule